// File: doc/BRIEF.md
# Frequency Sweep and Modulation Unit

This block owns the 11-bit pitch word of one special tone channel and changes it on a slow, programmable tick. In sweep mode every tick moves the pitch by a fraction of itself, `current >> shift`, either up or down. In table mode every tick sets the pitch to the last value written by software plus a signed entry from a 32-entry offset table. The table index walks forward one entry per step and either wraps or holds at the end.

The unit always keeps the following pitch prepared one step ahead. A tick loads the prepared value into the live pitch and at once prepares the one after it. Writing the mode byte also prepares a new value straight away. An upward sweep that runs past the 11-bit range raises a one-cycle request asking the channel owner to silence the channel. The tick period is the interval field multiplied by one of two clock bases. The channel's own oscillator lies outside this block.

Top module: `freq_sweep_mod`

## Requirements
- R1: After reset `freq_cur` is 0, `kill_req` is 0, the tick countdown is 0 and every table entry is 0.
- R2: The sweep-control byte holds the interval in bits 7:4, the base select in bit 7 (the same bit as the interval MSB), the direction in bit 3 and the shift in bits 2:0. The tick period is interval × FAST_CLKS cycles when bit 7 is 0 and interval × SLOW_CLKS cycles when bit 7 is 1. An interval of 0 produces no ticks.
- R3: In sweep mode (`cfg_mode`=0) the prepared value is `cur - (cur >> shift)` when the direction is 0 and `cur + (cur >> shift)` when it is 1.
- R4: If an upward sweep result exceeds 2047, `kill_req` is high for exactly the one cycle that follows the preparation.
- R5: In table mode (`cfg_mode`=1) the prepared value is (written frequency + sign-extended 8-bit entry[index]) mod 2048. The index then advances by one. At 31 it returns to 0 when repeat is set and otherwise stays at 31.
- R6: Ticks occur only while `chan_on` is high, the enable bit is set and the interval is non-zero. On a tick the prepared value becomes `freq_cur` and the next value is prepared in the same cycle. Outside a tick or a frequency write, `freq_cur` does not change.
- R7: A sweep-control write loads the countdown with the new period only if that period is smaller than the running count. It never makes the count larger.
- R8: A rising edge on `chan_on` loads the full period and resets the table index to 0. The first tick follows exactly one period later.
- R9: Table writes made while `chan_on` is high have no effect.
- R10: A `cfg_wr` prepares a new value in that cycle using the newly written mode and repeat. If it coincides with a tick, preparation happens once and uses the new mode together with the value just loaded.
- R11: `frq_wr` sets both the live and the written frequency. A preparation in the same cycle uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Sweep-control byte write strobe |
| ctl_data | input | 8 | Sweep-control byte |
| cfg_wr | input | 1 | Mode/enable write strobe |
| cfg_enable | input | 1 | Modification enable |
| cfg_mode | input | 1 | 0 = sweep, 1 = table |
| cfg_repeat | input | 1 | Table index wraps at its end |
| frq_wr | input | 1 | Frequency write strobe |
| frq_data | input | FREQ_W | Written frequency |
| chan_on | input | 1 | Channel enable level |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_addr | input | log2(TBL_DEPTH) | Table entry address |
| tbl_data | input | ENTRY_W | Signed table entry |
| freq_cur | output | FREQ_W | Live channel frequency |
| kill_req | output | 1 | One-cycle request to silence the channel |

## Verification
Two functions can land in the same cycle: the periodic tick and a mode/enable write. Both want to prepare the next value and to move the table index. The bench provokes this with a directed case that issues a table-mode write on the very edge where a sweep tick is due. It expects the swept value to go live and the following tick to deliver written + entry[0]. Random stimulus repeats this collision, and also the overlap of a control write with a tick reload, against a cycle model built from the requirements.

// File: rtl/fsm_pkg.sv
`timescale 1ns/1ps
package fsm_pkg;
   typedef enum logic {
      MODE_SWEEP = 1'b0,
      MODE_TABLE = 1'b1
   } fmod_mode_e;

   // sweep-control byte; ivl[3] doubles as the base select
   typedef struct packed {
      logic [3:0] ivl;
      logic       dir;
      logic [2:0] shift;
   } sweep_ctl_t;
endpackage

// File: rtl/fsm_tick_timer.sv
`timescale 1ns/1ps
module fsm_tick_timer
   import fsm_pkg::*;
#(
   parameter int FAST_CLKS = 19201,
   parameter int SLOW_CLKS = 153610,
   parameter int CNT_W     = 22
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chan_on,
   input  logic       mod_en,
   input  sweep_ctl_t ctl_q,
   input  sweep_ctl_t ctl_eff,
   input  logic       ctl_wr,
   output logic       tick,
   output logic       rise
);
   if (FAST_CLKS < 1 || SLOW_CLKS < 1) begin : g_bad_base
      $error("tick bases must be positive");
   end
   if (CNT_W < $clog2(15 * SLOW_CLKS + 1) || CNT_W < $clog2(15 * FAST_CLKS + 1)) begin : g_bad_cnt
      $error("countdown too narrow for the longest period");
   end

   function automatic logic [CNT_W-1:0] period_of(input sweep_ctl_t c);
      logic [CNT_W-1:0] base;
      base = c.ivl[3] ? CNT_W'(SLOW_CLKS) : CNT_W'(FAST_CLKS);
      return CNT_W'(c.ivl) * base;
   endfunction

   logic             on_q;
   logic             run;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec, period_new;

   assign rise       = chan_on & ~on_q;
   assign run        = chan_on & ~rise & mod_en & (ctl_q.ivl != 4'd0);
   assign tick       = run & (cnt_q <= CNT_W'(1));
   assign period_new = period_of(ctl_eff);

   always_comb begin
      cnt_dec = run ? cnt_q - CNT_W'(1) : cnt_q;
      if (rise || tick)
         cnt_d = period_new;
      else if (ctl_wr && (period_new < cnt_dec))
         cnt_d = period_new;
      else
         cnt_d = cnt_dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         on_q  <= chan_on;
         cnt_q <= cnt_d;
      end
   end

   // a control write never stretches the running countdown
   assert_no_lengthen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !tick && !rise) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/fsm_mod_table.sv
`timescale 1ns/1ps
module fsm_mod_table #(
   parameter int DEPTH          = 32,
   parameter int ENTRY_W        = 8,
   parameter int AW             = 5,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lock,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [ENTRY_W-1:0] rd_data
);
   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("table depth must equal 2**AW");
   end

   logic [ENTRY_W-1:0] mem_q [DEPTH];
   logic               wr_ok;

   assign wr_ok   = wr_en & ~lock;
   assign rd_data = mem_q[rd_addr];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (wr_ok) begin
            mem_q[wr_addr] <= wr_data;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_ok) mem_q[wr_addr] <= wr_data;
      end
   end

   // entries are frozen while the channel runs
   assert_tbl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && wr_en) |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])));
endmodule

// File: rtl/fsm_stage.sv
`timescale 1ns/1ps
module fsm_stage
   import fsm_pkg::*;
#(
   parameter int FREQ_W  = 11,
   parameter int ENTRY_W = 8,
   parameter int IDX_W   = 5
) (
   input  fmod_mode_e         mode,
   input  logic               repeat_en,
   input  logic               dir_up,
   input  logic [2:0]         shift,
   input  logic [FREQ_W-1:0]  cur,
   input  logic [FREQ_W-1:0]  written,
   input  logic [ENTRY_W-1:0] entry,
   input  logic [IDX_W-1:0]   idx_base,
   output logic [FREQ_W-1:0]  nxt,
   output logic               ovf,
   output logic [IDX_W-1:0]   idx_adv
);
   if (ENTRY_W >= FREQ_W) begin : g_bad_entry
      $error("table entries must be narrower than the frequency");
   end

   localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

   logic [FREQ_W:0]   sweep_sum;
   logic [FREQ_W-1:0] step_amt, mod_sum;

   always_comb begin
      step_amt  = cur >> shift;
      sweep_sum = dir_up ? ({1'b0, cur} + {1'b0, step_amt})
                         : ({1'b0, cur} - {1'b0, step_amt});
      mod_sum   = written + {{(FREQ_W-ENTRY_W){entry[ENTRY_W-1]}}, entry};
      nxt       = (mode == MODE_SWEEP) ? sweep_sum[FREQ_W-1:0] : mod_sum;
      ovf       = sweep_sum[FREQ_W];
      if (idx_base != LAST)
         idx_adv = idx_base + IDX_W'(1);
      else
         idx_adv = repeat_en ? '0 : LAST;
   end
endmodule

// File: rtl/freq_sweep_mod.sv
`timescale 1ns/1ps
module freq_sweep_mod
   import fsm_pkg::*;
#(
   parameter int FREQ_W    = 11,
   parameter int ENTRY_W   = 8,
   parameter int TBL_DEPTH = 32,
   parameter int FAST_CLKS = 19201,
   parameter int SLOW_CLKS = 153610,
   parameter bit TBL_CLEAR = 1'b1,
   localparam int IDX_W    = $clog2(TBL_DEPTH),
   localparam int CNT_W    = $clog2(15 * ((SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS) + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [7:0]         ctl_data,
   input  logic               cfg_wr,
   input  logic               cfg_enable,
   input  logic               cfg_mode,
   input  logic               cfg_repeat,
   input  logic               frq_wr,
   input  logic [FREQ_W-1:0]  frq_data,
   input  logic               chan_on,
   input  logic               tbl_wr,
   input  logic [IDX_W-1:0]   tbl_addr,
   input  logic [ENTRY_W-1:0] tbl_data,
   output logic [FREQ_W-1:0]  freq_cur,
   output logic               kill_req
);
   if (FREQ_W < 4) begin : g_bad_freq
      $error("frequency width too small");
   end

   sweep_ctl_t         ctl_q, ctl_eff;
   fmod_mode_e         mode_q, mode_eff;
   logic               rep_q, rep_eff, en_q, kill_q;
   logic               tick, rise, stage;
   logic [FREQ_W-1:0]  cur_q, cur_d, wr_q, wr_d, next_q, staged;
   logic [IDX_W-1:0]   idx_q, idx_base, idx_adv, idx_d;
   logic [ENTRY_W-1:0] entry;
   logic               ovf, kill_d;

   assign ctl_eff  = ctl_wr ? sweep_ctl_t'(ctl_data) : ctl_q;
   assign mode_eff = cfg_wr ? fmod_mode_e'(cfg_mode) : mode_q;
   assign rep_eff  = cfg_wr ? cfg_repeat : rep_q;
   assign cur_d    = frq_wr ? frq_data : (tick ? next_q : cur_q);
   assign wr_d     = frq_wr ? frq_data : wr_q;
   assign stage    = tick | cfg_wr;
   assign idx_base = rise ? '0 : idx_q;
   assign idx_d    = (stage && mode_eff == MODE_TABLE) ? idx_adv : idx_base;
   assign kill_d   = stage && (mode_eff == MODE_SWEEP) && ovf;

   fsm_tick_timer #(
      .FAST_CLKS(FAST_CLKS), .SLOW_CLKS(SLOW_CLKS), .CNT_W(CNT_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .mod_en(en_q),
      .ctl_q(ctl_q), .ctl_eff(ctl_eff), .ctl_wr(ctl_wr),
      .tick(tick), .rise(rise)
   );

   fsm_mod_table #(
      .DEPTH(TBL_DEPTH), .ENTRY_W(ENTRY_W), .AW(IDX_W), .CLEAR_ON_RESET(TBL_CLEAR)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .lock(chan_on), .wr_en(tbl_wr),
      .wr_addr(tbl_addr), .wr_data(tbl_data), .rd_addr(idx_base), .rd_data(entry)
   );

   fsm_stage #(
      .FREQ_W(FREQ_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)
   ) u_stage (
      .mode(mode_eff), .repeat_en(rep_eff), .dir_up(ctl_eff.dir), .shift(ctl_eff.shift),
      .cur(cur_d), .written(wr_d), .entry(entry), .idx_base(idx_base),
      .nxt(staged), .ovf(ovf), .idx_adv(idx_adv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         mode_q <= MODE_SWEEP;
         rep_q  <= 1'b0;
         en_q   <= 1'b0;
         cur_q  <= '0;
         wr_q   <= '0;
         next_q <= '0;
         idx_q  <= '0;
         kill_q <= 1'b0;
      end else begin
         ctl_q  <= ctl_eff;
         mode_q <= mode_eff;
         rep_q  <= rep_eff;
         if (cfg_wr) en_q <= cfg_enable;
         cur_q  <= cur_d;
         wr_q   <= wr_d;
         if (stage) next_q <= staged;
         idx_q  <= idx_d;
         kill_q <= kill_d;
      end
   end

   assign freq_cur = cur_q;
   assign kill_req = kill_q;

   // a silence request always traces back to a preparation
   assert_kill_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      kill_req |-> $past(stage));
   // pitch moves only on a tick or a frequency write
   assert_freq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!frq_wr && !tick) |=> $stable(freq_cur));
   // enabling the channel restarts the table walk
   assert_idx_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !stage) |=> (idx_q == '0));
endmodule

// File: tb/test_freq_sweep_mod.sv
`timescale 1ns/1ps
module test_freq_sweep_mod;
   localparam int FAST = 3;
   localparam int SLOW = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 0, cfg_wr = 0, cfg_enable = 0, cfg_mode = 0, cfg_repeat = 0;
   logic        frq_wr = 0, chan_on = 0, tbl_wr = 0;
   logic [7:0]  ctl_data = 0, tbl_data = 0;
   logic [10:0] frq_data = 0;
   logic [4:0]  tbl_addr = 0;
   logic [10:0] freq_cur;
   logic        kill_req;

   int  n_tests = 0, n_fail = 0;
   bit  model_cmp = 0, finished = 0;

   always #10 clk = ~clk;

   freq_sweep_mod #(.FAST_CLKS(FAST), .SLOW_CLKS(SLOW)) i_freq_sweep_mod (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_repeat(cfg_repeat),
      .frq_wr(frq_wr), .frq_data(frq_data), .chan_on(chan_on),
      .tbl_wr(tbl_wr), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
      .freq_cur(freq_cur), .kill_req(kill_req)
   );

   // ---------------- reference model built from the requirements ----------------
   logic [10:0] m_cur, m_wr, m_next;
   logic [4:0]  m_idx;
   logic [7:0]  m_ctl;
   logic        m_mode, m_rep, m_en, m_on, m_kill;
   int          m_cnt;
   logic [7:0]  m_tbl [32];

   function automatic int period_of(logic [7:0] c);
      return int'(c[7:4]) * (c[7] ? SLOW : FAST);
   endfunction

   always @(posedge clk) begin : model
      logic rise, act, tk, st, me, re, kn;
      logic [7:0] ce;
      int pn, d;
      logic [10:0] cn, wn, nx, sh;
      logic [11:0] sum;
      logic [4:0] ib, ixn;
      if (!rst_n) begin
         m_cur = 0; m_wr = 0; m_next = 0; m_idx = 0; m_ctl = 0;
         m_mode = 0; m_rep = 0; m_en = 0; m_on = 0; m_kill = 0; m_cnt = 0;
         for (int i = 0; i < 32; i++) m_tbl[i] = 0;
      end else begin
         rise = chan_on && !m_on;
         ce   = ctl_wr ? ctl_data : m_ctl;
         pn   = period_of(ce);
         act  = chan_on && !rise && m_en && (m_ctl[7:4] != 0);
         tk   = act && (m_cnt <= 1);
         cn   = frq_wr ? frq_data : (tk ? m_next : m_cur);
         wn   = frq_wr ? frq_data : m_wr;
         me   = cfg_wr ? cfg_mode : m_mode;
         re   = cfg_wr ? cfg_repeat : m_rep;
         ib   = rise ? 5'd0 : m_idx;
         st   = tk || cfg_wr;
         kn = 0; nx = m_next; ixn = ib;
         if (st) begin
            if (!me) begin
               sh  = cn >> ce[2:0];
               sum = ce[3] ? {1'b0, cn} + {1'b0, sh} : {1'b0, cn} - {1'b0, sh};
               kn  = sum > 12'd2047;
               nx  = sum[10:0];
            end else begin
               nx  = wn + {{3{m_tbl[ib][7]}}, m_tbl[ib]};
               ixn = (ib == 5'd31) ? (re ? 5'd0 : 5'd31) : ib + 5'd1;
            end
         end
         if (rise || tk) d = pn;
         else begin
            d = act ? m_cnt - 1 : m_cnt;
            if (ctl_wr && pn < d) d = pn;
         end
         if (tbl_wr && !chan_on) m_tbl[tbl_addr] = tbl_data;
         m_cur = cn; m_wr = wn; m_next = nx; m_idx = ixn; m_ctl = ce;
         m_mode = me; m_rep = re; m_on = chan_on; m_kill = kn; m_cnt = d;
         if (cfg_wr) m_en = cfg_enable;
      end
   end

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // model comparison every cycle: freq per R6, kill per R4
   always @(negedge clk) begin
      if (model_cmp && rst_n) begin
         check("R6", int'(freq_cur), int'(m_cur));
         check("R4", int'(kill_req), int'(m_kill));
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr_frq(int v);
      frq_wr = 1; frq_data = 11'(v); step(1); frq_wr = 0;
   endtask
   task automatic wr_ctl(int v);
      ctl_wr = 1; ctl_data = 8'(v); step(1); ctl_wr = 0;
   endtask
   task automatic wr_cfg(bit en, bit md, bit rp);
      cfg_wr = 1; cfg_enable = en; cfg_mode = md; cfg_repeat = rp; step(1); cfg_wr = 0;
   endtask
   task automatic wr_tbl(int a, int v);
      tbl_wr = 1; tbl_addr = 5'(a); tbl_data = 8'(v); step(1); tbl_wr = 0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20ns * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20241020));
      step(3);
      rst_n = 1;
      step(1);
      check("R1", int'(freq_cur), 0);
      check("R1", int'(kill_req), 0);
      model_cmp = 1;

      // sweep down, fast base, enabling edge timing
      wr_frq(1024);
      check("R11", int'(freq_cur), 1024);
      wr_ctl(8'h11);
      wr_cfg(1, 0, 0);
      chan_on = 1; step(1);
      step(2);
      check("R8", int'(freq_cur), 1024);
      step(1);
      check("R3", int'(freq_cur), 512);
      step(3);
      check("R3", int'(freq_cur), 256);
      chan_on = 0; step(2);

      // overflow on upward sweep
      wr_frq(1500);
      wr_ctl(8'h08);
      wr_cfg(1, 0, 0);
      check("R4", int'(kill_req), 1);
      step(1);
      check("R4", int'(kill_req), 0);
      wr_frq(1000);
      wr_cfg(1, 0, 0);
      check("R4", int'(kill_req), 0);

      // table mode without repeat
      for (int i = 0; i < 32; i++) wr_tbl(i, i - 16);
      wr_frq(100);
      wr_ctl(8'h10);
      wr_cfg(1, 1, 0);
      chan_on = 1; step(1);
      step(2);
      check("R8", int'(freq_cur), 100);
      step(1);
      check("R5", int'(freq_cur), 84);
      step(3);
      check("R5", int'(freq_cur), 84);
      step(3);
      check("R5", int'(freq_cur), 85);
      step(120);
      check("R5", int'(freq_cur), 115);
      wr_tbl(31, 0);
      step(9);
      check("R9", int'(freq_cur), 115);
      chan_on = 0; step(2);

      // slow base, shortening and non-lengthening control writes
      wr_frq(1024);
      wr_ctl(8'hF7);
      wr_cfg(1, 0, 0);
      chan_on = 1; step(1);
      step(10);
      check("R2", int'(freq_cur), 1024);
      wr_ctl(8'h17);
      step(2);
      check("R7", int'(freq_cur), 1024);
      step(1);
      check("R7", int'(freq_cur), 1016);
      wr_ctl(8'hF7);
      step(1);
      check("R7", int'(freq_cur), 1016);
      step(1);
      check("R7", int'(freq_cur), 1009);
      wr_ctl(8'h07);
      step(30);
      check("R2", int'(freq_cur), 1009);
      chan_on = 0; step(2);

      // mode write landing on a tick edge
      wr_frq(1024);
      wr_ctl(8'h11);
      wr_cfg(1, 0, 0);
      chan_on = 1; step(1);
      step(2);
      check("R10", int'(freq_cur), 1024);
      wr_cfg(1, 1, 1);
      check("R10", int'(freq_cur), 512);
      step(3);
      check("R10", int'(freq_cur), 1008);
      chan_on = 0; step(2);

      // constrained random against the model
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(199) == 0) chan_on = ~chan_on;
         ctl_wr = ($urandom_range(39) == 0);
         ctl_data = 8'($urandom);
         cfg_wr = ($urandom_range(29) == 0);
         cfg_enable = ($urandom_range(3) != 0);
         cfg_mode = 1'($urandom);
         cfg_repeat = 1'($urandom);
         frq_wr = ($urandom_range(49) == 0);
         frq_data = 11'($urandom);
         tbl_wr = ($urandom_range(4) == 0);
         tbl_addr = 5'($urandom);
         tbl_data = 8'($urandom);
         step(1);
      end
      ctl_wr = 0; cfg_wr = 0; frq_wr = 0; tbl_wr = 0;
      step(2);
      model_cmp = 0;
      finish_run();
   end
endmodule